// File: doc/BRIEF.md
# SIMD Lane-Element Access Decoder

This block is purely combinational. It takes the fields of a single-structure vector memory instruction and works out how the access is shaped. The inputs are the three opcode bits, the load flag, the half/full-width bit, the lane-extension bit, the register-count bit and the two-bit size field. From these the block produces:

- the element scale, with the element width in bits and in bytes;
- the lane that the access targets;
- how many consecutive registers take part (one to four);
- whether the element is broadcast to every lane of a load;
- the vector width;
- a flag for encodings that have no defined meaning.

Register file access, memory access, trapping and address generation are not part of this block. Downstream logic consumes the outputs and does that work. Whenever `undef_enc` is high, every other output is don't-care.

Top module: `lane_access_decoder`

## Requirements
- R1: `num_elems` equals the two-bit value {`opcode[0]`, `regcnt`} plus one, so it ranges from 1 to 4, for every encoding.
- R2: When `opcode[2:1]` is 3, the encoding is undefined if `is_load` is 0 or `lane_hi` is 1. Otherwise `broadcast` is 1, `eff_scale` equals `size`, and `lane_idx` is 0.
- R3: When `opcode[2:1]` is 0, the encoding is always defined, `eff_scale` is 0, and `lane_idx` is {`wide`, `lane_hi`, `size[1]`, `size[0]`} (lanes 0 to 15).
- R4: When `opcode[2:1]` is 1, `size[0]`=1 is undefined. Otherwise `eff_scale` is 1 and `lane_idx` is {0, `wide`, `lane_hi`, `size[1]`}.
- R5: When `opcode[2:1]` is 2, `size[1]`=1 is undefined. With `size` = 0, `eff_scale` is 2 and `lane_idx` is {0, 0, `wide`, `lane_hi`}.
- R6: When `opcode[2:1]` is 2 and `size` is 1, `lane_hi`=1 is undefined. Otherwise `eff_scale` is 3 and `lane_idx` is {0, 0, 0, `wide`}.
- R7: For a defined encoding, `elem_bits` is 8 shifted left by `eff_scale` and `elem_bytes` is `elem_bits` divided by 8.
- R8: For a defined encoding, `vec_bits` is 64 when `wide`=0 and 128 when `wide`=1.
- R9: `broadcast` is 0 whenever `opcode[2:1]` is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 3 | Opcode bits; [2:1] is the base scale field, [0] is the high register-count bit |
| is_load | input | 1 | 1 for a load, 0 for a store |
| wide | input | 1 | Vector width select, also the top lane bit |
| lane_hi | input | 1 | Lane-extension bit |
| regcnt | input | 1 | Low register-count bit |
| size | input | 2 | Size field |
| eff_scale | output | 2 | Final element scale (0 byte to 3 doubleword) |
| elem_bits | output | 7 | Element width in bits |
| elem_bytes | output | 4 | Element width in bytes |
| lane_idx | output | 4 | Lane index, zero-extended |
| num_elems | output | 3 | Registers in the structure, 1 to 4 |
| broadcast | output | 1 | Load-and-replicate form |
| vec_bits | output | 8 | Vector width in bits |
| undef_enc | output | 1 | Encoding is undefined |

## Verification
The bench builds the decoder with its default parameters: an 8-bit base element and a 64-bit base vector. With these the outputs have the widths in the table, so the bench can sweep all 512 combinations of the nine input bits. That sweep covers every undefined corner (store broadcast, odd halfword size, the doubleword/lane-extension clash) and every lane width from 16 lanes down to 2. Directed vectors that name the key cases come before the sweep.

// File: rtl/lane_dec_pkg.sv
package lane_dec_pkg;
  localparam int LANE_W = 4;

  typedef enum logic [1:0] {
    SC_BYTE = 2'd0,
    SC_HALF = 2'd1,
    SC_WORD = 2'd2,
    SC_DWRD = 2'd3
  } scale_e;

  typedef struct packed {
    scale_e              scale;
    logic [LANE_W-1:0]   idx;
    logic                bcast;
    logic                undef;
  } lane_dec_t;
endpackage

// File: rtl/lane_dec_classify.sv
module lane_dec_classify
  import lane_dec_pkg::*;
(
  input  logic [1:0] scale_fld,
  input  logic       is_load,
  input  logic       wide,
  input  logic       lane_hi,
  input  logic [1:0] size,
  output lane_dec_t  dec
);
  always_comb begin
    dec = '0;
    unique case (scale_fld)
      2'b00: begin
        dec.scale = SC_BYTE;
        dec.idx   = {wide, lane_hi, size};
      end
      2'b01: begin
        dec.scale = SC_HALF;
        dec.undef = size[0];
        dec.idx   = {1'b0, wide, lane_hi, size[1]};
      end
      2'b10: begin
        if (size[1]) begin
          dec.undef = 1'b1;
        end else if (!size[0]) begin
          dec.scale = SC_WORD;
          dec.idx   = {2'b00, wide, lane_hi};
        end else begin
          dec.scale = SC_DWRD;
          dec.undef = lane_hi;
          dec.idx   = {3'b000, wide};
        end
      end
      default: begin
        dec.undef = ~is_load | lane_hi;
        dec.bcast = is_load & ~lane_hi;
        dec.scale = scale_e'(size);
      end
    endcase
  end
endmodule

// File: rtl/lane_dec_widths.sv
module lane_dec_widths #(
  parameter int BASE_ELEM_BITS = 8,
  parameter int BASE_VEC_BITS  = 64,
  parameter int BITS_W         = 7,
  parameter int BYTES_W        = 4,
  parameter int VEC_W          = 8
) (
  input  logic [1:0]         scale,
  input  logic               wide,
  output logic [BITS_W-1:0]  elem_bits,
  output logic [BYTES_W-1:0] elem_bytes,
  output logic [VEC_W-1:0]   vec_bits
);
  localparam int BYTE_SHIFT = 3;

  function automatic logic [BITS_W-1:0] bits_of(input logic [1:0] sc);
    return BITS_W'(BASE_ELEM_BITS) << sc;
  endfunction

  function automatic logic [BYTES_W-1:0] bytes_of(input logic [BITS_W-1:0] b);
    return BYTES_W'(b >> BYTE_SHIFT);
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic w);
    return VEC_W'(BASE_VEC_BITS) << w;
  endfunction

  assign elem_bits  = bits_of(scale);
  assign elem_bytes = bytes_of(elem_bits);
  assign vec_bits   = vec_of(wide);
endmodule

// File: rtl/lane_dec_count.sv
module lane_dec_count #(
  parameter int CNT_W = 3
) (
  input  logic             cnt_hi,
  input  logic             cnt_lo,
  output logic [CNT_W-1:0] num_elems
);
  function automatic logic [CNT_W-1:0] count_of(input logic [1:0] code);
    return CNT_W'(code) + CNT_W'(1);
  endfunction

  assign num_elems = count_of({cnt_hi, cnt_lo});
endmodule

// File: rtl/lane_access_decoder.sv
module lane_access_decoder
  import lane_dec_pkg::*;
#(
  parameter int BASE_ELEM_BITS = 8,
  parameter int BASE_VEC_BITS  = 64,
  localparam int BITS_W  = $clog2(BASE_ELEM_BITS << 3) + 1,
  localparam int BYTES_W = $clog2(BASE_ELEM_BITS) + 1,
  localparam int VEC_W   = $clog2(BASE_VEC_BITS << 1) + 1,
  localparam int CNT_W   = 3
) (
  input  logic [2:0]         opcode,
  input  logic               is_load,
  input  logic               wide,
  input  logic               lane_hi,
  input  logic               regcnt,
  input  logic [1:0]         size,
  output logic [1:0]         eff_scale,
  output logic [BITS_W-1:0]  elem_bits,
  output logic [BYTES_W-1:0] elem_bytes,
  output logic [LANE_W-1:0]  lane_idx,
  output logic [CNT_W-1:0]   num_elems,
  output logic               broadcast,
  output logic [VEC_W-1:0]   vec_bits,
  output logic               undef_enc
);
  lane_dec_t dec_w;

  lane_dec_classify u_classify (
    .scale_fld (opcode[2:1]),
    .is_load   (is_load),
    .wide      (wide),
    .lane_hi   (lane_hi),
    .size      (size),
    .dec       (dec_w)
  );

  lane_dec_widths #(
    .BASE_ELEM_BITS (BASE_ELEM_BITS),
    .BASE_VEC_BITS  (BASE_VEC_BITS),
    .BITS_W         (BITS_W),
    .BYTES_W        (BYTES_W),
    .VEC_W          (VEC_W)
  ) u_widths (
    .scale      (dec_w.scale),
    .wide       (wide),
    .elem_bits  (elem_bits),
    .elem_bytes (elem_bytes),
    .vec_bits   (vec_bits)
  );

  lane_dec_count #(.CNT_W(CNT_W)) u_count (
    .cnt_hi    (opcode[0]),
    .cnt_lo    (regcnt),
    .num_elems (num_elems)
  );

  assign eff_scale = dec_w.scale;
  assign lane_idx  = dec_w.idx;
  assign broadcast = dec_w.bcast;
  assign undef_enc = dec_w.undef;
endmodule

// File: rtl/lane_access_decoder_chk.sv
module lane_access_decoder_chk #(
  parameter int BITS_W  = 7,
  parameter int BYTES_W = 4,
  parameter int VEC_W   = 8,
  parameter int BASE_VEC_BITS = 64
) (
  input logic [2:0]         opcode,
  input logic               is_load,
  input logic               wide,
  input logic               lane_hi,
  input logic               regcnt,
  input logic [1:0]         size,
  input logic [1:0]         eff_scale,
  input logic [BITS_W-1:0]  elem_bits,
  input logic [BYTES_W-1:0] elem_bytes,
  input logic [3:0]         lane_idx,
  input logic [2:0]         num_elems,
  input logic               broadcast,
  input logic [VEC_W-1:0]   vec_bits,
  input logic               undef_enc
);
  logic known;
  assign known = !$isunknown({opcode, is_load, wide, lane_hi, regcnt, size});

  always_comb begin
    if (known) begin
      p_count_in_range_r1: assert (num_elems >= 3'd1 && num_elems <= 3'd4);
      p_bcast_needs_load_r2: assert (!broadcast || (is_load && !lane_hi && opcode[2:1] == 2'b11 && !undef_enc));
      p_byte_always_defined_r3: assert (opcode[2:1] != 2'b00 || (!undef_enc && eff_scale == 2'd0));
      p_bits_bytes_agree_r7: assert (undef_enc || ({1'b0, elem_bits} == ({4'd0, elem_bytes} << 3)));
      p_vec_tracks_wide_r8: assert (undef_enc || (vec_bits == (VEC_W'(BASE_VEC_BITS) << wide)));
      p_no_bcast_off_field_r9: assert (opcode[2:1] == 2'b11 || !broadcast);
      p_halfword_lane_msb_zero_r4: assert (undef_enc || opcode[2:1] != 2'b01 || !lane_idx[3]);
    end
  end
endmodule

bind lane_access_decoder lane_access_decoder_chk #(
  .BITS_W        (BITS_W),
  .BYTES_W       (BYTES_W),
  .VEC_W         (VEC_W),
  .BASE_VEC_BITS (BASE_VEC_BITS)
) u_chk (
  .opcode     (opcode),
  .is_load    (is_load),
  .wide       (wide),
  .lane_hi    (lane_hi),
  .regcnt     (regcnt),
  .size       (size),
  .eff_scale  (eff_scale),
  .elem_bits  (elem_bits),
  .elem_bytes (elem_bytes),
  .lane_idx   (lane_idx),
  .num_elems  (num_elems),
  .broadcast  (broadcast),
  .vec_bits   (vec_bits),
  .undef_enc  (undef_enc)
);

// File: tb/test_lane_access_decoder.sv
`timescale 1ns/1ps
module test_lane_access_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [2:0] opcode;
  logic is_load, wide, lane_hi, regcnt;
  logic [1:0] size;
  logic [1:0] eff_scale;
  logic [6:0] elem_bits;
  logic [3:0] elem_bytes;
  logic [3:0] lane_idx;
  logic [2:0] num_elems;
  logic broadcast, undef_enc;
  logic [7:0] vec_bits;

  lane_access_decoder i_lane_access_decoder (
    .opcode(opcode), .is_load(is_load), .wide(wide), .lane_hi(lane_hi),
    .regcnt(regcnt), .size(size), .eff_scale(eff_scale), .elem_bits(elem_bits),
    .elem_bytes(elem_bytes), .lane_idx(lane_idx), .num_elems(num_elems),
    .broadcast(broadcast), .vec_bits(vec_bits), .undef_enc(undef_enc)
  );

  typedef struct {
    logic       undef;
    logic [1:0] scale;
    logic [6:0] bits;
    logic [3:0] bytes;
    logic [3:0] idx;
    logic [2:0] num;
    logic       rep;
    logic [7:0] vec;
    string      sreq;
    string      rreq;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  function automatic exp_t model(logic [2:0] op, logic l, logic q, logic s, logic r, logic [1:0] sz);
    exp_t e;
    logic [3:0] full;
    int sh;
    full = {q, s, sz};
    e.num = 3'({op[0], r}) + 3'd1;
    e.vec = q ? 8'd128 : 8'd64;
    e.rep = 1'b0;
    e.idx = 4'd0;
    e.rreq = (op[2:1] == 2'd3) ? "R2" : "R9";
    case (op[2:1])
      2'd0: begin e.sreq = "R3"; e.undef = 0; sh = 0; end
      2'd1: begin e.sreq = "R4"; e.undef = sz[0]; sh = 1; end
      2'd2: begin
        if (sz == 2'd1) begin e.sreq = "R6"; e.undef = s; sh = 3; end
        else begin e.sreq = "R5"; e.undef = sz[1]; sh = 2; end
      end
      default: begin e.sreq = "R2"; e.undef = !l || s; sh = int'(sz); e.rep = !e.undef; end
    endcase
    e.scale = 2'(sh);
    if (op[2:1] != 2'd3) e.idx = full >> sh;
    e.bits = 7'(8 * (1 << sh));
    e.bytes = 4'(1 << sh);
    return e;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic l, logic q, logic s, logic r, logic [1:0] sz);
    @(posedge clk);
    #1;
    opcode = op; is_load = l; wide = q; lane_hi = s; regcnt = r; size = sz;
    sb.push_back(model(op, l, q, s, r, sz));
  endtask

  // Monitor: pops one expected item per cycle at the falling edge.
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp("R1", "num_elems", int'(num_elems), int'(e.num));
      cmp(e.sreq, "undef", int'(undef_enc), int'(e.undef));
      cmp(e.rreq, "broadcast", int'(broadcast), int'(e.rep));
      if (!e.undef) begin
        cmp(e.sreq, "scale", int'(eff_scale), int'(e.scale));
        cmp(e.sreq, "lane_idx", int'(lane_idx), int'(e.idx));
        cmp("R7", "elem_bits", int'(elem_bits), int'(e.bits));
        cmp("R7", "elem_bytes", int'(elem_bytes), int'(e.bytes));
        cmp("R8", "vec_bits", int'(vec_bits), int'(e.vec));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    opcode = 0; is_load = 0; wide = 0; lane_hi = 0; regcnt = 0; size = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state vector: all-zero fields give byte lane 0, one register (R1, R3)
    drive(3'b000, 0, 0, 0, 0, 2'd0);
    // R2: store broadcast undefined, load broadcast with lane_hi undefined, valid broadcast
    drive(3'b110, 0, 1, 0, 0, 2'd2);
    drive(3'b110, 1, 0, 1, 0, 2'd1);
    drive(3'b111, 1, 1, 0, 1, 2'd3);
    // R3: byte lane 15
    drive(3'b000, 0, 1, 1, 1, 2'd3);
    // R4: halfword odd size undefined, lane 7
    drive(3'b010, 1, 0, 0, 0, 2'd1);
    drive(3'b011, 0, 1, 1, 0, 2'd2);
    // R5: word lane 3, size[1] undefined
    drive(3'b100, 0, 1, 1, 0, 2'd0);
    drive(3'b101, 1, 0, 0, 1, 2'd2);
    // R6: doubleword lane 1, doubleword with lane_hi undefined
    drive(3'b100, 0, 1, 0, 0, 2'd1);
    drive(3'b100, 0, 1, 1, 0, 2'd1);
    // Exhaustive sweep over all nine input bits (R1..R9)
    for (int v = 0; v < 512; v++) begin
      logic [8:0] b;
      b = 9'(v);
      drive(b[8:6], b[5], b[4], b[3], b[2], b[1:0]);
    end
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule